// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the programmable front end of a colour LCD controller. A host reaches it through a simple single-cycle bus strobe over a 4 KB byte window. The window holds four panel timing words, the frame base addresses for the upper and lower panels, a control word, an interrupt mask, and interrupt status views. It also contains a 128-word palette store and a read-only identification area. The block feeds the pixel engine around it directly. It decodes the panel width and height from packed timing fields, and it presents the control flags, the bits-per-pixel code and a display-active qualifier.

The pixel engine raises interrupt causes as one-cycle event pulses. The block latches them, masks them and combines them into a single interrupt line. Software clears a cause by writing 1 to its bit. A static strap selects one of two register layouts: the layouts exchange the positions of the control and mask words and report different identification bytes. Each read returns its data one cycle after the access strobe. An access to a location that has no function returns zero, changes nothing and raises an error flag for one cycle.

Top module: `lcdc_regif`

## Requirements
- R1: Reset clears every register, including the palette. After reset `disp_on_o` and `irq_o` are 0, `ppl_o` is 16 and `lpp_o` is 1.
- R2: A read (`acc_i`=1, `write_i`=0) drives `rvalid_o`=1 with its data on `rdata_o` in the next cycle. Whenever `rvalid_o` is 0, `rdata_o` is zero.
- R3: Word offsets 0x000–0x00C are four 32-bit timing words and read back what was written. Offset 0x010 is the upper frame base and 0x014 is the lower frame base; both read back and drive `upper_base_o` and `lower_base_o`.
- R4: With `variant_i`=0 the control word is at 0x018 and the mask is at 0x01C. With `variant_i`=1 the two are exchanged. The mask keeps NUM_IRQ bits, and the control word keeps bits [3:0] and [11:8]; all other bits read zero.
- R5: Control bit 0 is enable and bit 11 is power; `disp_on_o` is 1 only when both are 1. `bpp_o` is bits [3:1]. `bgr_o` is bit 8, `be_byte_o` is bit 9 and `be_pix_o` is bit 10.
- R6: `ppl_o` = ((timing0 & 0xFC) + 4) × 4 and `lpp_o` = (timing1 & 0x3FF) + 1.
- R7: Offsets 0x200–0x3FC form 128 read/write palette words, and entry n is at 0x200 + 4n.
- R8: Offsets 0xFE0–0xFFC read identification bytes in bits [7:0], with upper bits zero. For `variant_i`=0 the bytes are 10 11 04 00 0D F0 05 B1, and for `variant_i`=1 they are 11 11 24 00 0D F0 05 B1, in ascending address order.
- R9: A 1 on `irq_evt_i[k]` sets status bit k. Offset 0x020 reads raw status and 0x024 reads status AND mask. `irq_o` is 1 when any masked status bit is 1.
- R10: Writing offset 0x028 clears each status bit written as 1. If an event and a clear hit the same bit in the same cycle, the bit ends set.
- R11: Offsets 0x02C and 0x030 read as zero without error.
- R12: A read of an offset outside the readable set (which excludes 0x028) or a write to an offset outside 0x000–0x01C, 0x028 and the palette returns zero and changes no state. It pulses `err_o` for one cycle in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | Register layout strap, static after reset |
| acc_i | input | 1 | Single-cycle access strobe |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte address in the window |
| wdata_i | input | DATA_W (32) | Write data |
| irq_evt_i | input | NUM_IRQ (4) | One-cycle interrupt cause pulses |
| rdata_o | output | DATA_W (32) | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| err_o | output | 1 | Access without function |
| irq_o | output | 1 | OR of masked status |
| disp_on_o | output | 1 | Enable and power both set |
| bpp_o | output | 3 | Bits-per-pixel code |
| bgr_o | output | 1 | Blue/red swap |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |
| ppl_o | output | 11 | Pixels per line |
| lpp_o | output | 11 | Lines per panel |
| upper_base_o | output | DATA_W (32) | Upper panel frame base |
| lower_base_o | output | DATA_W (32) | Lower panel frame base |

## Verification
The assertions take it for granted that the layout strap holds still outside reset. They also assume that `write_i` and `addr_i` are meaningful whenever `acc_i` is high. The bench changes `variant_i` only while reset is held and drives the bus only at falling edges, using word-aligned addresses. Interrupt events come in any pattern, including the same cycle as a clear. No property depends on their timing, apart from the rule that a set wins over a clear.

// File: rtl/lcdc_reg_pkg.sv
package lcdc_reg_pkg;

  // word indices inside the register block
  localparam int unsigned W_TIM0   = 0;
  localparam int unsigned W_UPBASE = 4;
  localparam int unsigned W_LPBASE = 5;
  localparam int unsigned W_SLOT_A = 6;
  localparam int unsigned W_SLOT_B = 7;
  localparam int unsigned W_RAW    = 8;
  localparam int unsigned W_MSK    = 9;
  localparam int unsigned W_CLR    = 10;
  localparam int unsigned W_CUR_U  = 11;
  localparam int unsigned W_CUR_L  = 12;

  localparam int unsigned PAL_BASE_W = 'h080;  // byte 0x200
  localparam int unsigned ID_BASE_W  = 'h3F8;  // byte 0xFE0

  localparam logic [11:0] CTRL_KEEP = 12'hF0F;

  localparam int unsigned PPL_W = 11;
  localparam int unsigned LPP_W = 11;

  typedef struct packed {
    logic       pwr;
    logic       be_pix;
    logic       be_byte;
    logic       bgr;
    logic [2:0] bpp;
    logic       en;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic v, input logic [2:0] i);
    case (i)
      3'd0:    return v ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return v ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_palette.sv
module lcdc_palette #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               clr_we_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic [NUM_IRQ-1:0] msk_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic               irq_o
);

  logic [NUM_IRQ-1:0] raw_q, mask_q, clr_vec;

  assign clr_vec = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | evt_i;  // set wins
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign msk_o  = raw_q & mask_q;
  assign irq_o  = |msk_o;

endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_reg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] tim0_i,
  input  logic [DATA_W-1:0] tim1_i,
  output logic [PPL_W-1:0]  ppl_o,
  output logic [LPP_W-1:0]  lpp_o
);

  logic [6:0] ppl_units;

  // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
  assign ppl_units = {1'b0, tim0_i[7:2]} + 7'd1;
  assign ppl_o     = {ppl_units, 4'b0000};
  assign lpp_o     = {1'b0, tim1_i[9:0]} + 11'd1;

  logic unused_geom;
  assign unused_geom = ^{tim0_i[DATA_W-1:8], tim0_i[1:0], tim1_i[DATA_W-1:10]};

endmodule

// File: rtl/lcdc_regif.sv
module lcdc_regif
  import lcdc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_IRQ   = 4,
  parameter int unsigned PAL_WORDS = 128,
  parameter int unsigned NUM_TIM   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               variant_i,
  input  logic               acc_i,
  input  logic               write_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] irq_evt_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               err_o,
  output logic               irq_o,
  output logic               disp_on_o,
  output logic [2:0]         bpp_o,
  output logic               bgr_o,
  output logic               be_byte_o,
  output logic               be_pix_o,
  output logic [PPL_W-1:0]   ppl_o,
  output logic [LPP_W-1:0]   lpp_o,
  output logic [DATA_W-1:0]  upper_base_o,
  output logic [DATA_W-1:0]  lower_base_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned PAL_AW = $clog2(PAL_WORDS);

  // ---- address decode ----
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] pal_off;
  logic [3:0]        reg_idx;
  logic              in_pal, in_id, in_reg;
  logic [3:0]        ctrl_idx, mask_idx;

  assign word     = addr_i[ADDR_W-1:2];
  assign pal_off  = word - WORD_W'(PAL_BASE_W);
  assign in_pal   = (word >= WORD_W'(PAL_BASE_W)) &&
                    (word <  WORD_W'(PAL_BASE_W + PAL_WORDS));
  assign in_id    = (word >= WORD_W'(ID_BASE_W));
  assign reg_idx  = word[3:0];
  assign in_reg   = (word[WORD_W-1:4] == '0) && (reg_idx <= 4'(W_CUR_L));
  assign ctrl_idx = variant_i ? 4'(W_SLOT_B) : 4'(W_SLOT_A);
  assign mask_idx = variant_i ? 4'(W_SLOT_A) : 4'(W_SLOT_B);

  logic rd_req, wr_req;
  assign rd_req = acc_i & ~write_i;
  assign wr_req = acc_i &  write_i;

  // ---- write strobes ----
  logic               wr_legal;
  logic [NUM_TIM-1:0] tim_we;
  logic               up_we, lp_we, ctrl_we, mask_we, clr_we, pal_we;

  assign up_we   = wr_req && in_reg && reg_idx == 4'(W_UPBASE);
  assign lp_we   = wr_req && in_reg && reg_idx == 4'(W_LPBASE);
  assign ctrl_we = wr_req && in_reg && reg_idx == ctrl_idx;
  assign mask_we = wr_req && in_reg && reg_idx == mask_idx;
  assign clr_we  = wr_req && in_reg && reg_idx == 4'(W_CLR);
  assign pal_we  = wr_req && in_pal;

  assign wr_legal = in_pal ||
                    (in_reg && (reg_idx <= 4'(W_SLOT_B) || reg_idx == 4'(W_CLR)));

  // ---- timing registers ----
  logic [DATA_W-1:0] tim_q [NUM_TIM];

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    assign tim_we[g] = wr_req && in_reg && reg_idx == 4'(W_TIM0 + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tim_q[g] <= '0;
      else if (tim_we[g]) tim_q[g] <= wdata_i;
    end
  end

  // ---- base and control registers ----
  logic [DATA_W-1:0] up_q, lp_q;
  logic [11:0]       ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= '0;
      lp_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (up_we)   up_q   <= wdata_i;
      if (lp_we)   lp_q   <= wdata_i;
      if (ctrl_we) ctrl_q <= wdata_i[11:0] & CTRL_KEEP;
    end
  end

  ctrl_t ctrl;
  assign ctrl = '{pwr: ctrl_q[11], be_pix: ctrl_q[10], be_byte: ctrl_q[9],
                  bgr: ctrl_q[8], bpp: ctrl_q[3:1], en: ctrl_q[0]};

  // ---- interrupts ----
  logic [NUM_IRQ-1:0] raw_stat, msk_stat, irq_mask;

  lcdc_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (irq_evt_i),
    .clr_we_i  (clr_we),
    .clr_i     (wdata_i[NUM_IRQ-1:0]),
    .mask_we_i (mask_we),
    .mask_i    (wdata_i[NUM_IRQ-1:0]),
    .raw_o     (raw_stat),
    .msk_o     (msk_stat),
    .mask_o    (irq_mask),
    .irq_o     (irq_o)
  );

  // ---- palette ----
  logic [DATA_W-1:0] pal_rdata;

  lcdc_palette #(.WORDS(PAL_WORDS), .DATA_W(DATA_W)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pal_we),
    .idx_i   (pal_off[PAL_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (pal_rdata)
  );

  // ---- geometry ----
  lcdc_geom #(.DATA_W(DATA_W)) u_geom (
    .tim0_i (tim_q[0]),
    .tim1_i (tim_q[1]),
    .ppl_o  (ppl_o),
    .lpp_o  (lpp_o)
  );

  // ---- read mux ----
  logic [DATA_W-1:0] rd_val;
  logic              rd_legal;

  always_comb begin
    rd_val   = '0;
    rd_legal = 1'b0;
    if (in_pal) begin
      rd_val   = pal_rdata;
      rd_legal = 1'b1;
    end else if (in_id) begin
      rd_val   = {{(DATA_W-8){1'b0}}, id_byte(variant_i, word[2:0])};
      rd_legal = 1'b1;
    end else if (in_reg) begin
      rd_legal = 1'b1;
      if (reg_idx < 4'(NUM_TIM))          rd_val = tim_q[reg_idx[1:0]];
      else if (reg_idx == 4'(W_UPBASE))   rd_val = up_q;
      else if (reg_idx == 4'(W_LPBASE))   rd_val = lp_q;
      else if (reg_idx == ctrl_idx)       rd_val = DATA_W'(ctrl_q);
      else if (reg_idx == mask_idx)       rd_val = DATA_W'(irq_mask);
      else if (reg_idx == 4'(W_RAW))      rd_val = DATA_W'(raw_stat);
      else if (reg_idx == 4'(W_MSK))      rd_val = DATA_W'(msk_stat);
      else if (reg_idx == 4'(W_CLR))      rd_legal = 1'b0;
      // current-address words read zero
    end
  end

  // ---- response ----
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      rdata_q  <= (rd_req && rd_legal) ? rd_val : '0;
      err_q    <= (rd_req && !rd_legal) || (wr_req && !wr_legal);
    end
  end

  assign rdata_o      = rdata_q;
  assign rvalid_o     = rvalid_q;
  assign err_o        = err_q;
  assign disp_on_o    = ctrl.en & ctrl.pwr;
  assign bpp_o        = ctrl.bpp;
  assign bgr_o        = ctrl.bgr;
  assign be_byte_o    = ctrl.be_byte;
  assign be_pix_o     = ctrl.be_pix;
  assign upper_base_o = up_q;
  assign lower_base_o = lp_q;

  logic unused_regif;
  assign unused_regif = ^{addr_i[1:0], pal_off[WORD_W-1:PAL_AW], tim_we,
                          wdata_i[DATA_W-1:12]};

endmodule

// File: rtl/lcdc_regif_chk.sv
module lcdc_regif_chk
  import lcdc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IRQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               variant_i,
  input logic               acc_i,
  input logic               write_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_IRQ-1:0] irq_evt_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               rvalid_o,
  input logic               err_o,
  input logic               irq_o,
  input logic [PPL_W-1:0]   ppl_o,
  input logic [LPP_W-1:0]   lpp_o,
  input logic [NUM_IRQ-1:0] status_i,
  input logic [NUM_IRQ-1:0] mask_i
);

  assert_strap_static_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(variant_i));

  assert_rd_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !write_i) |=> rvalid_o);

  assert_rd_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));

  assert_err_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));

  assert_err_after_acc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(acc_i));

  assert_geom_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppl_o[3:0] == 4'd0) && (ppl_o >= PPL_W'(16)) && (lpp_o != '0));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_evt_i != '0) |=> ((status_i & $past(irq_evt_i)) == $past(irq_evt_i)));

  assert_no_mask_no_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  assert_id_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !write_i && addr_i[ADDR_W-1:5] == '1) |=> (rdata_o[DATA_W-1:8] == '0));

endmodule

bind lcdc_regif lcdc_regif_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .variant_i (variant_i),
  .acc_i     (acc_i),
  .write_i   (write_i),
  .addr_i    (addr_i),
  .irq_evt_i (irq_evt_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .err_o     (err_o),
  .irq_o     (irq_o),
  .ppl_o     (ppl_o),
  .lpp_o     (lpp_o),
  .status_i  (raw_stat),
  .mask_i    (irq_mask)
);

// File: tb/lcdc_regif_tb_top.sv
module lcdc_regif_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        variant_i = 1'b0;
  logic        acc_i = 1'b0;
  logic        write_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  irq_evt_i = '0;
  logic [31:0] rdata_o, upper_base_o, lower_base_o;
  logic        rvalid_o, err_o, irq_o, disp_on_o, bgr_o, be_byte_o, be_pix_o;
  logic [2:0]  bpp_o;
  logic [10:0] ppl_o, lpp_o;

  always #5 clk_i = ~clk_i;

  lcdc_regif dut_i (
    .clk_i, .rst_ni, .variant_i, .acc_i, .write_i, .addr_i, .wdata_i, .irq_evt_i,
    .rdata_o, .rvalid_o, .err_o, .irq_o, .disp_on_o, .bpp_o, .bgr_o, .be_byte_o,
    .be_pix_o, .ppl_o, .lpp_o, .upper_base_o, .lower_base_o
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses
  always @(negedge clk_i) begin
    if (rst_ni && (rvalid_o || err_o)) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected response: actual %h/%b expected none", rdata_o, err_o);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (rdata_o !== it.data || err_o !== it.err) begin
          n_fail++;
          $display("FAIL %s: actual %h err %b expected %h err %b",
                   it.tag, rdata_o, err_o, it.data, it.err);
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    acc_i = 1'b1; write_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    acc_i = 1'b0; write_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back('{e, 1'b0, tag});
    access(1'b0, a, '0);
  endtask

  task automatic rd_err(input logic [11:0] a, input string tag);
    exp_q.push_back('{32'h0, 1'b1, tag});
    access(1'b0, a, '0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    access(1'b1, a, d);
  endtask

  task automatic wr_err(input logic [11:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back('{32'h0, 1'b1, tag});
    access(1'b1, a, d);
  endtask

  task automatic pulse(input logic [3:0] b);
    @(negedge clk_i); irq_evt_i = b;
    @(negedge clk_i); irq_evt_i = '0;
  endtask

  task automatic do_reset(input logic v);
    @(negedge clk_i);
    rst_ni = 1'b0; variant_i = v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] id0 [8];
    logic [7:0] id1 [8];
    id0 = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    id1 = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    do_reset(1'b0);
    // R1 reset state
    chk(32'(disp_on_o), 0, "R1 disp_on");
    chk(32'(irq_o), 0, "R1 irq");
    chk(32'(ppl_o), 16, "R1 ppl");
    chk(32'(lpp_o), 1, "R1 lpp");
    chk(rdata_o, 0, "R2 idle rdata");
    rd(12'h018, 0, "R1 ctrl reset");
    rd(12'h01C, 0, "R1 mask reset");

    // R3 / R6 timing and geometry
    wr(12'h000, 32'h0000_00FC);
    chk(32'(ppl_o), 1024, "R6 ppl max");
    rd(12'h000, 32'h0000_00FC, "R3 tim0");
    wr(12'h000, 32'h1234_5678);
    chk(32'(ppl_o), 496, "R6 ppl mixed");
    rd(12'h000, 32'h1234_5678, "R3 tim0 full");
    wr(12'h004, 32'h0000_03FF);
    chk(32'(lpp_o), 1024, "R6 lpp max");
    wr(12'h004, 32'hFFFF_F805);
    chk(32'(lpp_o), 6, "R6 lpp masked");
    wr(12'h008, 32'hCAFE_0002);
    wr(12'h00C, 32'h0000_7777);
    rd(12'h008, 32'hCAFE_0002, "R3 tim2");
    rd(12'h00C, 32'h0000_7777, "R3 tim3");
    wr(12'h010, 32'hDEAD_BEE0);
    wr(12'h014, 32'h0BAD_F00D);
    chk(upper_base_o, 32'hDEAD_BEE0, "R3 upper out");
    chk(lower_base_o, 32'h0BAD_F00D, "R3 lower out");
    rd(12'h010, 32'hDEAD_BEE0, "R3 upper rd");
    rd(12'h014, 32'h0BAD_F00D, "R3 lower rd");

    // R4 / R5 control, variant 0
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, 32'h0000_0F0F, "R4 ctrl kept bits");
    chk(32'({disp_on_o, bpp_o, bgr_o, be_byte_o, be_pix_o}), 32'h7F, "R5 all flags");
    wr(12'h018, 32'h0000_0001);
    chk(32'(disp_on_o), 0, "R5 en only");
    wr(12'h018, 32'h0000_0800);
    chk(32'(disp_on_o), 0, "R5 pwr only");
    wr(12'h018, 32'h0000_0A0B);
    chk(32'({disp_on_o, bpp_o, bgr_o, be_byte_o, be_pix_o}), 32'b1_101_0_1_0, "R5 mixed");
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, 32'h0000_000F, "R4 mask width");

    // R9 / R10 interrupts
    wr(12'h01C, 32'h0000_0005);
    pulse(4'b0011);
    rd(12'h020, 32'h3, "R9 raw");
    rd(12'h024, 32'h1, "R9 masked");
    chk(32'(irq_o), 1, "R9 irq high");
    wr(12'h028, 32'h1);
    rd(12'h020, 32'h2, "R10 w1c raw");
    chk(32'(irq_o), 0, "R10 irq cleared");
    @(negedge clk_i);
    acc_i = 1'b1; write_i = 1'b1; addr_i = 12'h028; wdata_i = 32'h4; irq_evt_i = 4'b0100;
    @(negedge clk_i);
    acc_i = 1'b0; write_i = 1'b0; wdata_i = '0; irq_evt_i = '0;
    rd(12'h020, 32'h6, "R10 set beats clear");
    chk(32'(irq_o), 1, "R10 irq after set-clear");
    wr(12'h028, 32'hF);
    rd(12'h020, 32'h0, "R10 clear all");

    // R11 current-address words
    rd(12'h02C, 0, "R11 cur upper");
    rd(12'h030, 0, "R11 cur lower");

    // R7 palette
    wr(12'h200, 32'hA5A5_0001);
    wr(12'h3FC, 32'h1234_0000);
    wr(12'h300, 32'h0F0F_F0F0);
    rd(12'h200, 32'hA5A5_0001, "R7 pal first");
    rd(12'h3FC, 32'h1234_0000, "R7 pal last");
    rd(12'h300, 32'h0F0F_F0F0, "R7 pal mid");
    rd(12'h204, 32'h0, "R7 pal untouched");

    // R8 identification, variant 0
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i), 32'(id0[i]), "R8 id v0");

    // R12 undefined accesses
    rd_err(12'h034, "R12 rd gap");
    rd_err(12'h400, "R12 rd hole");
    rd_err(12'h028, "R12 rd clear word");
    wr_err(12'h020, 32'hF, "R12 wr raw");
    rd(12'h020, 32'h0, "R12 raw unchanged");
    wr_err(12'h034, 32'hFFFF_FFFF, "R12 wr gap");
    wr_err(12'hFE0, 32'hFF, "R12 wr id");
    rd(12'h000, 32'h1234_5678, "R12 tim0 unchanged");
    chk(32'(ppl_o), 496, "R12 ppl unchanged");
    rd(12'hFE0, 32'(id0[0]), "R12 id unchanged");

    // variant 1
    do_reset(1'b1);
    rd(12'h200, 32'h0, "R1 palette reset");
    chk(upper_base_o, 0, "R1 base reset");
    wr(12'h01C, 32'h0000_0801);
    chk(32'(disp_on_o), 1, "R4 v1 ctrl slot");
    wr(12'h018, 32'h0000_0003);
    rd(12'h018, 32'h3, "R4 v1 mask slot");
    rd(12'h01C, 32'h801, "R4 v1 ctrl readback");
    pulse(4'b1010);
    rd(12'h024, 32'h2, "R9 v1 masked");
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i), 32'(id1[i]), "R8 id v1");

    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 missing responses: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end

endmodule